// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a display, together with the column and row of the pixel being shown. It runs entirely in the pixel clock domain. The active picture size, the two sync widths, the four porches and the level of each of the three strobes are configuration inputs. They are sampled only on the last clock of a frame. A frame therefore always completes with the values it started with.

Every line passes through four phases in the order sync, back porch, active and front porch. The frame passes through the same four phases counted in lines. Each phase length must be at least one. The pixel clock can often be set only in coarse steps. To cope with this, a target frame period in pixel clocks can be supplied. The generator then stretches only the horizontal front porch of the final line of the frame, so that the whole frame lasts exactly that long. All earlier lines keep their nominal length.

Both counters are built from one phase sequencer. Its four named states are SYNC, BACK, ACTIVE and FRONT. On every step it moves SYNC to BACK, BACK to ACTIVE, ACTIVE to FRONT and FRONT to SYNC. The horizontal sequencer advances on every clock. The vertical sequencer advances only when a line wraps. Reset puts both sequencers in SYNC with a count of zero.

Top module: `raster_top`

## Requirements
- R1: After reset the active configuration is the built-in default: 1280x640 active, horizontal sync 40, both horizontal porches 50, vertical sync 20 lines, vertical back porch 31, vertical front porch 30, horizontal and vertical sync active low, data enable active high, and a target period equal to the default pixel clock divided by 60 frames per second. The first frame after reset uses this configuration whatever the inputs carry.
- R2: Each line consists of hsync_len_i clocks of sync, hback_len_i clocks of back porch, hact_len_i active clocks and hfront_len_i clocks of front porch, in that order. The horizontal sync strobe is asserted only during the sync phase.
- R3: The frame consists of vsync_len_i lines of sync, vback_len_i lines of back porch, vact_len_i active lines and vfront_len_i lines of front porch, in that order. The vertical phase changes only where one line ends and the next begins.
- R4: de_o is asserted exactly when both sequencers are in their active phase. At such a clock x_o and y_o give the zero-based column and row inside the active picture. At every other clock both are 0.
- R5: Each strobe has its own polarity input, where 1 means active high and 0 means active low. An asserted strobe drives the pin to the polarity value and a deasserted one drives its inverse.
- R6: If frame_period_i exceeds the nominal frame length (line total times line count), the front porch of the last line alone is lengthened by the difference. Otherwise the frame keeps its nominal length. A value of 0 disables the limit.
- R7: Configuration inputs are captured only on the final clock of a frame. A change made mid-frame has no effect until the next frame starts.
- R8: frame_start_o is high for exactly one clock, the first clock of every frame, when both sequencers are in SYNC with a count of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hsync_len_i | input | CW | Horizontal sync width in clocks |
| hback_len_i | input | CW | Horizontal back porch in clocks |
| hact_len_i | input | CW | Active pixels per line |
| hfront_len_i | input | CW | Horizontal front porch in clocks |
| vsync_len_i | input | CW | Vertical sync width in lines |
| vback_len_i | input | CW | Vertical back porch in lines |
| vact_len_i | input | CW | Active lines per frame |
| vfront_len_i | input | CW | Vertical front porch in lines |
| hsync_pol_i | input | 1 | Horizontal sync polarity, 1 = active high |
| vsync_pol_i | input | 1 | Vertical sync polarity, 1 = active high |
| de_pol_i | input | 1 | Data enable polarity, 1 = active high |
| frame_period_i | input | PW | Target frame period in clocks, 0 = no limit |
| hsync_o | output | 1 | Horizontal sync pin level |
| vsync_o | output | 1 | Vertical sync pin level |
| de_o | output | 1 | Data enable pin level |
| x_o | output | CW | Active column, 0 outside the active area |
| y_o | output | CW | Active row, 0 outside the active area |
| frame_start_o | output | 1 | One-clock pulse on the first clock of a frame |

## Verification
A cycle-accurate reference raster runs beside the design. It is fed with geometries of several shapes: one with wide porches, one with every phase a single unit long, and one with an uneven sync of several lines. Between them, these shapes separate off-by-one errors in each phase boundary and in the order of the phases.

Each geometry is paired with a target period above, equal to, one above and below its nominal frame length, and with zero. These cases expose errors in the stretch arithmetic and in the clamp. Inverted polarity sets distinguish a pin level from the internal strobe. New inputs are applied during the first frame after reset and again mid-frame. This shows that the defaults, and then the old values, govern until the frame boundary, including after a reset taken in the middle of a frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Phase shared by the horizontal and vertical sequencers
    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_t;

    // Built-in timing used after reset
    localparam int DEF_HSYNC  = 40;
    localparam int DEF_HBACK  = 50;
    localparam int DEF_HACT   = 1280;
    localparam int DEF_HFRONT = 50;
    localparam int DEF_VSYNC  = 20;
    localparam int DEF_VBACK  = 31;
    localparam int DEF_VACT   = 640;
    localparam int DEF_VFRONT = 30;
    localparam int DEF_PCLK_KHZ = 61150;
    localparam int DEF_FPS      = 60;
    localparam int DEF_PERIOD   = (DEF_PCLK_KHZ * 1000) / DEF_FPS;

    function automatic phase_t phase_after(input phase_t p);
        unique case (p)
            PH_SYNC:   return PH_BACK;
            PH_BACK:   return PH_ACTIVE;
            PH_ACTIVE: return PH_FRONT;
            PH_FRONT:  return PH_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/raster_cfg.sv
module raster_cfg
    import raster_pkg::*;
#(
    parameter int CW = 12,
    parameter int PW = 24,
    parameter int D_HSYNC = DEF_HSYNC,
    parameter int D_HBACK = DEF_HBACK,
    parameter int D_HACT = DEF_HACT,
    parameter int D_HFRONT = DEF_HFRONT,
    parameter int D_VSYNC = DEF_VSYNC,
    parameter int D_VBACK = DEF_VBACK,
    parameter int D_VACT = DEF_VACT,
    parameter int D_VFRONT = DEF_VFRONT,
    parameter int D_PERIOD = DEF_PERIOD
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [CW-1:0] hsync_len_i,
    input  logic [CW-1:0] hback_len_i,
    input  logic [CW-1:0] hact_len_i,
    input  logic [CW-1:0] hfront_len_i,
    input  logic [CW-1:0] vsync_len_i,
    input  logic [CW-1:0] vback_len_i,
    input  logic [CW-1:0] vact_len_i,
    input  logic [CW-1:0] vfront_len_i,
    input  logic          hsync_pol_i,
    input  logic          vsync_pol_i,
    input  logic          de_pol_i,
    input  logic [PW-1:0] frame_period_i,
    output logic [CW-1:0] sh_hsync_o,
    output logic [CW-1:0] sh_hback_o,
    output logic [CW-1:0] sh_hact_o,
    output logic [CW-1:0] sh_hfront_o,
    output logic [CW-1:0] sh_vsync_o,
    output logic [CW-1:0] sh_vback_o,
    output logic [CW-1:0] sh_vact_o,
    output logic [CW-1:0] sh_vfront_o,
    output logic          sh_hpol_o,
    output logic          sh_vpol_o,
    output logic          sh_depol_o,
    output logic [PW-1:0] sh_extra_o
);
    localparam int MW = (PW > 2 * CW + 4) ? PW : 2 * CW + 4;
    localparam longint D_NOM = longint'(D_HSYNC + D_HBACK + D_HACT + D_HFRONT) *
                               longint'(D_VSYNC + D_VBACK + D_VACT + D_VFRONT);
    localparam longint D_EXTRA = (longint'(D_PERIOD) > D_NOM) ? longint'(D_PERIOD) - D_NOM : 0;

    logic [MW-1:0] line_total, line_count, nominal, target;
    logic [PW-1:0] extra_next;

    // Stretch of the final line, computed from the values about to be captured
    always_comb begin
        line_total = MW'(hsync_len_i) + MW'(hback_len_i) + MW'(hact_len_i) + MW'(hfront_len_i);
        line_count = MW'(vsync_len_i) + MW'(vback_len_i) + MW'(vact_len_i) + MW'(vfront_len_i);
        nominal    = line_total * line_count;
        target     = MW'(frame_period_i);
        extra_next = (target > nominal) ? PW'(target - nominal) : '0;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_hsync_o  <= CW'(D_HSYNC);
            sh_hback_o  <= CW'(D_HBACK);
            sh_hact_o   <= CW'(D_HACT);
            sh_hfront_o <= CW'(D_HFRONT);
            sh_vsync_o  <= CW'(D_VSYNC);
            sh_vback_o  <= CW'(D_VBACK);
            sh_vact_o   <= CW'(D_VACT);
            sh_vfront_o <= CW'(D_VFRONT);
            sh_hpol_o   <= 1'b0;
            sh_vpol_o   <= 1'b0;
            sh_depol_o  <= 1'b1;
            sh_extra_o  <= PW'(D_EXTRA);
        end else if (load_i) begin
            sh_hsync_o  <= hsync_len_i;
            sh_hback_o  <= hback_len_i;
            sh_hact_o   <= hact_len_i;
            sh_hfront_o <= hfront_len_i;
            sh_vsync_o  <= vsync_len_i;
            sh_vback_o  <= vback_len_i;
            sh_vact_o   <= vact_len_i;
            sh_vfront_o <= vfront_len_i;
            sh_hpol_o   <= hsync_pol_i;
            sh_vpol_o   <= vsync_pol_i;
            sh_depol_o  <= de_pol_i;
            sh_extra_o  <= extra_next;
        end
    end
endmodule

// File: rtl/raster_phase.sv
module raster_phase
    import raster_pkg::*;
#(
    parameter int W  = 24,
    parameter int CW = 12
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          step_i,
    input  logic [CW-1:0] len_sync_i,
    input  logic [CW-1:0] len_back_i,
    input  logic [CW-1:0] len_act_i,
    input  logic [CW-1:0] len_front_i,
    input  logic [W-1:0]  extra_i,
    output phase_t        phase_o,
    output logic [CW-1:0] pos_o,
    output logic          wrap_o
);
    phase_t        state, state_nx;
    logic [W-1:0]  cnt, last;
    logic          done;

    // Final count of the current phase; FRONT carries the stretch
    always_comb begin
        unique case (state)
            PH_SYNC:   last = W'(len_sync_i) - W'(1);
            PH_BACK:   last = W'(len_back_i) - W'(1);
            PH_ACTIVE: last = W'(len_act_i) - W'(1);
            PH_FRONT:  last = W'(len_front_i) + extra_i - W'(1);
        endcase
        done     = step_i && (cnt == last);
        state_nx = done ? phase_after(state) : state;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state <= PH_SYNC;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (done)
                cnt <= '0;
            else if (step_i)
                cnt <= cnt + W'(1);
        end
    end

    always_comb begin
        phase_o = state;
        pos_o   = cnt[CW-1:0];
        wrap_o  = done && (state == PH_FRONT);
    end
endmodule

// File: rtl/raster_top.sv
module raster_top
    import raster_pkg::*;
#(
    parameter int CW = 12,
    parameter int PW = 24,
    parameter int D_HSYNC = DEF_HSYNC,
    parameter int D_HBACK = DEF_HBACK,
    parameter int D_HACT = DEF_HACT,
    parameter int D_HFRONT = DEF_HFRONT,
    parameter int D_VSYNC = DEF_VSYNC,
    parameter int D_VBACK = DEF_VBACK,
    parameter int D_VACT = DEF_VACT,
    parameter int D_VFRONT = DEF_VFRONT,
    parameter int D_PERIOD = DEF_PERIOD
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [CW-1:0] hsync_len_i,
    input  logic [CW-1:0] hback_len_i,
    input  logic [CW-1:0] hact_len_i,
    input  logic [CW-1:0] hfront_len_i,
    input  logic [CW-1:0] vsync_len_i,
    input  logic [CW-1:0] vback_len_i,
    input  logic [CW-1:0] vact_len_i,
    input  logic [CW-1:0] vfront_len_i,
    input  logic          hsync_pol_i,
    input  logic          vsync_pol_i,
    input  logic          de_pol_i,
    input  logic [PW-1:0] frame_period_i,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o,
    output logic          frame_start_o
);
    logic [CW-1:0] sh_hsync, sh_hback, sh_hact, sh_hfront;
    logic [CW-1:0] sh_vsync, sh_vback, sh_vact, sh_vfront;
    logic          sh_hpol, sh_vpol, sh_depol;
    logic [PW-1:0] sh_extra, h_extra;
    phase_t        h_phase, v_phase;
    logic [CW-1:0] h_pos, v_pos;
    logic          h_wrap, v_wrap, last_line, de_on;

    raster_cfg #(
        .CW(CW), .PW(PW),
        .D_HSYNC(D_HSYNC), .D_HBACK(D_HBACK), .D_HACT(D_HACT), .D_HFRONT(D_HFRONT),
        .D_VSYNC(D_VSYNC), .D_VBACK(D_VBACK), .D_VACT(D_VACT), .D_VFRONT(D_VFRONT),
        .D_PERIOD(D_PERIOD)
    ) u_cfg (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(v_wrap),
        .hsync_len_i(hsync_len_i), .hback_len_i(hback_len_i),
        .hact_len_i(hact_len_i), .hfront_len_i(hfront_len_i),
        .vsync_len_i(vsync_len_i), .vback_len_i(vback_len_i),
        .vact_len_i(vact_len_i), .vfront_len_i(vfront_len_i),
        .hsync_pol_i(hsync_pol_i), .vsync_pol_i(vsync_pol_i), .de_pol_i(de_pol_i),
        .frame_period_i(frame_period_i),
        .sh_hsync_o(sh_hsync), .sh_hback_o(sh_hback), .sh_hact_o(sh_hact),
        .sh_hfront_o(sh_hfront), .sh_vsync_o(sh_vsync), .sh_vback_o(sh_vback),
        .sh_vact_o(sh_vact), .sh_vfront_o(sh_vfront),
        .sh_hpol_o(sh_hpol), .sh_vpol_o(sh_vpol), .sh_depol_o(sh_depol),
        .sh_extra_o(sh_extra)
    );

    // Stretch applies only while the last line of the frame is running
    always_comb begin
        last_line = (v_phase == PH_FRONT) && (v_pos == sh_vfront - CW'(1));
        h_extra   = last_line ? sh_extra : '0;
    end

    raster_phase #(.W(PW), .CW(CW)) u_hor (
        .clk_i(clk_i), .rst_i(rst_i), .step_i(1'b1),
        .len_sync_i(sh_hsync), .len_back_i(sh_hback),
        .len_act_i(sh_hact), .len_front_i(sh_hfront),
        .extra_i(h_extra),
        .phase_o(h_phase), .pos_o(h_pos), .wrap_o(h_wrap)
    );

    raster_phase #(.W(CW), .CW(CW)) u_ver (
        .clk_i(clk_i), .rst_i(rst_i), .step_i(h_wrap),
        .len_sync_i(sh_vsync), .len_back_i(sh_vback),
        .len_act_i(sh_vact), .len_front_i(sh_vfront),
        .extra_i('0),
        .phase_o(v_phase), .pos_o(v_pos), .wrap_o(v_wrap)
    );

    // Output decode from the two sequencer states
    always_comb begin
        de_on         = (h_phase == PH_ACTIVE) && (v_phase == PH_ACTIVE);
        hsync_o       = (h_phase == PH_SYNC) ? sh_hpol : ~sh_hpol;
        vsync_o       = (v_phase == PH_SYNC) ? sh_vpol : ~sh_vpol;
        de_o          = de_on ? sh_depol : ~sh_depol;
        x_o           = de_on ? h_pos : '0;
        y_o           = de_on ? v_pos : '0;
        frame_start_o = (h_phase == PH_SYNC) && (h_pos == '0) &&
                        (v_phase == PH_SYNC) && (v_pos == '0);
    end
endmodule

// File: rtl/raster_top_chk.sv
module raster_top_chk
    import raster_pkg::*;
#(
    parameter int CW = 12,
    parameter int PW = 24
) (
    input logic          clk_i,
    input logic          rst_i,
    input phase_t        h_phase,
    input phase_t        v_phase,
    input logic          frame_end,
    input logic [CW-1:0] sh_hact,
    input logic [PW-1:0] sh_extra,
    input logic          de_on,
    input logic [CW-1:0] x_o,
    input logic          frame_start_o
);
    function automatic phase_t succ(input phase_t p);
        case (p)
            PH_SYNC:   return PH_BACK;
            PH_BACK:   return PH_ACTIVE;
            PH_ACTIVE: return PH_FRONT;
            default:   return PH_SYNC;
        endcase
    endfunction

    assert_h_order_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (h_phase != $past(h_phase)) |-> (h_phase == succ($past(h_phase))));

    assert_v_order_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (v_phase != $past(v_phase)) |-> (v_phase == succ($past(v_phase))));

    assert_v_at_line_end_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (v_phase != $past(v_phase)) |-> ($past(h_phase) == PH_FRONT && h_phase == PH_SYNC));

    assert_x_step_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(de_on) && de_on) |-> (x_o == $past(x_o) + CW'(1)));

    assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !frame_end |=> ($stable(sh_hact) && $stable(sh_extra)));

    assert_start_single_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |=> !frame_start_o);

    assert_start_origin_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start_o |-> (h_phase == PH_SYNC && v_phase == PH_SYNC));
endmodule

bind raster_top raster_top_chk #(.CW(CW), .PW(PW)) u_chk (
    .clk_i(clk_i), .rst_i(rst_i),
    .h_phase(h_phase), .v_phase(v_phase),
    .frame_end(v_wrap), .sh_hact(sh_hact), .sh_extra(sh_extra),
    .de_on(de_on), .x_o(x_o), .frame_start_o(frame_start_o)
);

// File: tb/raster_top_test.sv
`timescale 1ns/1ps
module raster_top_test;
    localparam int CW = 12;
    localparam int PW = 24;
    // Small reset geometry: line 15 clocks, 8 lines, nominal 120, target 130
    localparam int DH[4] = '{2, 3, 8, 2};
    localparam int DV[4] = '{1, 2, 4, 1};
    localparam int DPER = 130;
    // hs hb ha hf vs vb va vf hpol vpol depol period expected_len
    localparam int NV = 6;
    localparam int VEC[NV][13] = '{
        '{2, 3, 8, 2, 1, 2, 4, 1, 0, 0, 1,   0, 120},
        '{2, 3, 8, 2, 1, 2, 4, 1, 0, 0, 1, 200, 200},
        '{2, 3, 8, 2, 1, 2, 4, 1, 0, 0, 1, 100, 120},
        '{1, 1, 4, 1, 1, 1, 3, 1, 1, 1, 0,  50,  50},
        '{3, 2, 5, 4, 2, 1, 2, 2, 1, 0, 1,  98,  98},
        '{3, 2, 5, 4, 2, 1, 2, 2, 1, 0, 1,  99,  99}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [CW-1:0] hs_l, hb_l, ha_l, hf_l, vs_l, vb_l, va_l, vf_l;
    logic hp, vp, dp;
    logic [PW-1:0] per;
    logic hsync_o, vsync_o, de_o, frame_start_o;
    logic [CW-1:0] x_o, y_o;

    int n_chk = 0, n_bad = 0;
    bit running = 0;
    int t, since, last_len;
    int m[12];
    int htot, vtot, nom, flen, line, px, ex, ey;
    bit eh, ev, ede;
    logic [31:0] act_w, exp_w;

    always #4 clk = ~clk;

    raster_top #(
        .CW(CW), .PW(PW),
        .D_HSYNC(DH[0]), .D_HBACK(DH[1]), .D_HACT(DH[2]), .D_HFRONT(DH[3]),
        .D_VSYNC(DV[0]), .D_VBACK(DV[1]), .D_VACT(DV[2]), .D_VFRONT(DV[3]),
        .D_PERIOD(DPER)
    ) uut (
        .clk_i(clk), .rst_i(rst),
        .hsync_len_i(hs_l), .hback_len_i(hb_l), .hact_len_i(ha_l), .hfront_len_i(hf_l),
        .vsync_len_i(vs_l), .vback_len_i(vb_l), .vact_len_i(va_l), .vfront_len_i(vf_l),
        .hsync_pol_i(hp), .vsync_pol_i(vp), .de_pol_i(dp), .frame_period_i(per),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .x_o(x_o), .y_o(y_o), .frame_start_o(frame_start_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int i);
        @(posedge clk); #2;
        hs_l = CW'(VEC[i][0]); hb_l = CW'(VEC[i][1]); ha_l = CW'(VEC[i][2]); hf_l = CW'(VEC[i][3]);
        vs_l = CW'(VEC[i][4]); vb_l = CW'(VEC[i][5]); va_l = CW'(VEC[i][6]); vf_l = CW'(VEC[i][7]);
        hp = VEC[i][8][0]; vp = VEC[i][9][0]; dp = VEC[i][10][0]; per = PW'(VEC[i][11]);
    endtask

    task automatic load_defaults();
        m = '{DH[0], DH[1], DH[2], DH[3], DV[0], DV[1], DV[2], DV[3], 0, 0, 1, DPER};
    endtask

    task automatic wait_fs();
        do begin
            @(negedge clk); #1;
        end while (!frame_start_o);
    endtask

    task automatic check_reset_pins(input string tag);
        @(negedge clk); #1;
        check({hsync_o, vsync_o, de_o, frame_start_o} == 4'b0001 && x_o == 0 && y_o == 0,
              tag, int'({hsync_o, vsync_o, de_o, frame_start_o}), 1);
    endtask

    // Reference raster, one position per clock
    always @(negedge clk) begin
        if (running) begin
            htot = m[0] + m[1] + m[2] + m[3];
            vtot = m[4] + m[5] + m[6] + m[7];
            nom  = htot * vtot;
            flen = (m[11] > nom) ? m[11] : nom;
            if (t >= (vtot - 1) * htot) line = vtot - 1;
            else line = t / htot;
            px  = t - line * htot;
            eh  = px < m[0];
            ev  = line < m[4];
            ede = (px >= m[0] + m[1]) && (px < m[0] + m[1] + m[2]) &&
                  (line >= m[4] + m[5]) && (line < m[4] + m[5] + m[6]);
            ex  = ede ? px - m[0] - m[1] : 0;
            ey  = ede ? line - m[4] - m[5] : 0;
            act_w = {4'b0, x_o, y_o, hsync_o, vsync_o, de_o, frame_start_o};
            exp_w = {4'b0, CW'(ex), CW'(ey), eh ? m[8][0] : ~m[8][0], ev ? m[9][0] : ~m[9][0],
                     ede ? m[10][0] : ~m[10][0], t == 0};
            // R2 R3 R4 R5 R8: pin levels and coordinates at every clock
            n_chk++;
            if (act_w !== exp_w) begin
                n_bad++;
                $display("FAIL R2/R3/R4/R5/R8 t=%0d actual=%h expected=%h", t, act_w, exp_w);
            end
            if (frame_start_o) begin
                last_len = since;
                since = 1;
            end else since++;
            if (t == flen - 1) begin
                t = 0;
                m = '{int'(hs_l), int'(hb_l), int'(ha_l), int'(hf_l), int'(vs_l), int'(vb_l),
                      int'(va_l), int'(vf_l), int'(hp), int'(vp), int'(dp), int'(per)};
            end else t++;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // Inputs differ from the defaults during the first frame (R1, R7)
        hs_l = 1; hb_l = 1; ha_l = 4; hf_l = 1; vs_l = 1; vb_l = 1; va_l = 3; vf_l = 1;
        hp = 1; vp = 1; dp = 0; per = 50;
        repeat (4) @(posedge clk);
        check_reset_pins("R1 reset pins");
        @(posedge clk); #2;
        rst = 0; load_defaults(); t = 0; since = 0; running = 1;
        wait_fs();
        wait_fs();
        check(last_len == 130, "R1 R6 default frame length", last_len, 130);
        wait_fs();
        check(last_len == 50, "R7 inputs taken at boundary", last_len, 50);
        // Table walk: geometry, polarity and period limit patterns (R6, R7)
        for (int i = 0; i < NV; i++) begin
            apply(i);
            wait_fs();
            wait_fs();
            check(last_len == VEC[i][12], $sformatf("R6 vector %0d frame length", i),
                  last_len, VEC[i][12]);
        end
        // Reset taken mid-frame restores defaults and the frame origin
        repeat (7) @(posedge clk);
        #2; rst = 1; running = 0;
        @(posedge clk);
        check_reset_pins("R1 mid-frame reset pins");
        @(posedge clk); #2;
        rst = 0; load_defaults(); t = 0; since = 0; running = 1;
        wait_fs();
        wait_fs();
        check(last_len == 130, "R1 default frame after second reset", last_len, 130);
        wait_fs();
        check(last_len == 99, "R7 held inputs applied next frame", last_len, 99);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule